// File: doc/BRIEF.md
# Serial Transition Detector Trio

This block watches a single-bit serial stream and raises a flag each time the newest bit differs from the one before it, which is the same as saying that a 01 or 10 pair has just gone by. Three detectors that implement the same rule sit side by side and share the clock, the reset and the serial input. The three flags can therefore be compared in the same cycle to show how the output style of a state machine sets its output latency.

The first detector is a Moore machine whose flag depends only on its state. The second is a Mealy machine whose flag is a combinational function of the stored last bit and the live input. The third is a synchronous Mealy machine, which registers the Mealy flag on the rising edge. The input is expected to change on the falling edge of the clock, so every value is settled half a cycle before the rising edge that samples it.

A synchronous active-high reset returns all three detectors to their start condition.

Top module: `xdet_trio`

## Requirements
- R1: After a rising edge samples a bit that differs from the bit sampled at the previous rising edge, `moore_flag` is 1 until the next rising edge. After a rising edge samples a bit equal to the previous one, it is 0.
- R2: The first bit sampled after reset never raises `moore_flag`, whatever its value.
- R3: Once a bit has been sampled, `mealy_flag` equals `din` XOR (last sampled bit). It follows `din` with no clock edge in between.
- R4: `mealy_flag` is 0 from reset until the first bit after reset has been sampled, whatever the value on `din`.
- R5: `smealy_flag` holds, for a whole cycle, the value that `mealy_flag` had just before the rising edge that starts that cycle.
- R6: `moore_flag` and `smealy_flag` are equal in every cycle.
- R7: A rising edge with `rst` high clears all three flags. They stay low until a bit that differs from an earlier bit is sampled after reset is released.
- R8: `rst` takes priority over `din`. A bit that would have caused a transition is discarded when it is sampled with `rst` high.
- R9: A run of equal bits of any length keeps all three flags at 0 after the first bit of the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, changed on the falling edge |
| moore_flag | output | 1 | Transition flag decoded from the Moore state |
| mealy_flag | output | 1 | Combinational Mealy transition flag |
| smealy_flag | output | 1 | Registered Mealy transition flag |

## Verification
The properties assume that `din` is stable around each rising edge. The value a property samples for `mealy_flag` at an edge is then the value of the bit being taken in, and the one-cycle relations between the Mealy flag and the two registered flags hold exactly. The bench changes `din` and `rst` only just after a falling edge, as the block's timing rule expects. It reads the combinational flag shortly after that change and the registered flags shortly after the rising edge. Reset is applied only at falling edges, so the properties that key on reset see whole cycles of it.

// File: rtl/xdet_pkg.sv
package xdet_pkg;

    typedef enum logic [2:0] {
        XS_START     = 3'd0,
        XS_LOW_HOLD  = 3'd1,
        XS_HIGH_HOLD = 3'd2,
        XS_LOW_FLIP  = 3'd3,
        XS_HIGH_FLIP = 3'd4
    } moore_state_t;

    typedef struct packed {
        logic valid;
        logic last;
    } bit_hist_t;

    localparam bit_hist_t HIST_CLEAR = '{valid: 1'b0, last: 1'b0};

    function automatic logic state_is_low(input moore_state_t s);
        return (s == XS_LOW_HOLD) || (s == XS_LOW_FLIP);
    endfunction

    function automatic logic state_is_high(input moore_state_t s);
        return (s == XS_HIGH_HOLD) || (s == XS_HIGH_FLIP);
    endfunction

    function automatic moore_state_t moore_step(input moore_state_t s, input logic b);
        moore_state_t n;
        if (state_is_low(s))
            n = b ? XS_HIGH_FLIP : XS_LOW_HOLD;
        else if (state_is_high(s))
            n = b ? XS_HIGH_HOLD : XS_LOW_FLIP;
        else
            n = b ? XS_HIGH_HOLD : XS_LOW_HOLD;
        return n;
    endfunction

    function automatic logic moore_decode(input moore_state_t s);
        return (s == XS_LOW_FLIP) || (s == XS_HIGH_FLIP);
    endfunction

    function automatic logic hist_differs(input bit_hist_t h, input logic b);
        return h.valid & (h.last ^ b);
    endfunction

endpackage

// File: rtl/xdet_moore.sv
module xdet_moore
    import xdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic flag
);
    moore_state_t state_q;
    moore_state_t state_d;

    always_comb begin
        state_d = moore_step(state_q, din);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= XS_START;
        else
            state_q <= state_d;
    end

    assign flag = moore_decode(state_q);
endmodule

// File: rtl/xdet_mealy.sv
module xdet_mealy
    import xdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic flag
);
    bit_hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= HIST_CLEAR;
        else
            hist_q <= '{valid: 1'b1, last: din};
    end

    assign flag = hist_differs(hist_q, din);
endmodule

// File: rtl/xdet_flag_reg.sv
module xdet_flag_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/xdet_trio.sv
module xdet_trio
    import xdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic moore_flag,
    output logic mealy_flag,
    output logic smealy_flag
);
    logic mealy_comb;

    xdet_moore u_moore (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .flag (moore_flag)
    );

    xdet_mealy u_mealy (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .flag (mealy_comb)
    );

    xdet_flag_reg #(.W(1)) u_sreg (
        .clk (clk),
        .rst (rst),
        .d   (mealy_comb),
        .q   (smealy_flag)
    );

    assign mealy_flag = mealy_comb;
endmodule

// File: rtl/xdet_trio_chk.sv
module xdet_trio_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic moore_flag,
    input logic mealy_flag,
    input logic smealy_flag
);
    // R6: the Moore and registered Mealy flags agree in every cycle
    p_moore_eq_smealy_r6: assert property (@(posedge clk) disable iff (rst)
        moore_flag == smealy_flag)
        else $error("moore/smealy mismatch");

    // R5: the registered flag carries the Mealy value seen at the previous edge
    p_smealy_follows_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> smealy_flag == $past(mealy_flag))
        else $error("smealy does not follow mealy");

    // R1: the Moore flag raised after an edge at which the Mealy flag was high
    p_moore_after_mealy_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> moore_flag == $past(mealy_flag))
        else $error("moore flag latency wrong");

    // R7: an edge with reset high clears all flags
    p_reset_clears_r7: assert property (@(posedge clk)
        rst |=> (!moore_flag && !smealy_flag && !mealy_flag))
        else $error("flags not cleared by reset");

    // R4: at the first edge after reset the Mealy flag is still held low
    p_first_bit_quiet_r4: assert property (@(posedge clk)
        $fell(rst) |-> !mealy_flag)
        else $error("mealy flag high before first sample");

    // R2: the first sampled bit does not raise the Moore flag
    p_first_bit_moore_r2: assert property (@(posedge clk)
        $fell(rst) |=> !moore_flag)
        else $error("moore flag raised by first bit");

    // R9: two equal bits in a row leave the Moore flag low
    p_run_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!mealy_flag && !$rose(din) && !$fell(din)) |=> !moore_flag)
        else $error("flag raised inside a run");
endmodule

bind xdet_trio xdet_trio_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .moore_flag  (moore_flag),
    .mealy_flag  (mealy_flag),
    .smealy_flag (smealy_flag)
);

// File: tb/xdet_trio_tb.sv
module xdet_trio_tb;
    localparam int  NBITS  = 9;
    localparam logic [NBITS-1:0] STREAM = 9'b001011010;  // first bit at MSB
    localparam logic [NBITS-1:0] EXPECT = 9'b001110111;  // Moore flag per bit

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic moore_flag, mealy_flag, smealy_flag;

    int vectors = 0;
    int misses  = 0;
    logic have_prev = 1'b0;
    logic prev_bit  = 1'b0;
    logic done      = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    xdet_trio u_dut (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .moore_flag  (moore_flag),
        .mealy_flag  (mealy_flag),
        .smealy_flag (smealy_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // drive one bit on a falling edge, check the live Mealy flag, then the
    // registered flags after the rising edge that samples it
    task automatic step(input logic b, input logic r, input string req,
                        input logic use_tab, input logic tab_exp);
        logic e;
        @(negedge clk);
        din = b;
        rst = r;
        #1;
        e = have_prev && (b != prev_bit);
        check(have_prev ? "R3" : "R4", "mealy_flag live", mealy_flag, e);
        if (use_tab)
            check(req, "table vs model", e, tab_exp);
        @(posedge clk);
        #1;
        if (r) begin
            e = 1'b0;
            have_prev = 1'b0;
            check("R8", "moore_flag under reset", moore_flag, 1'b0);
            check("R7", "mealy_flag after reset edge", mealy_flag, 1'b0);
        end else begin
            prev_bit  = b;
            have_prev = 1'b1;
            check(req, "moore_flag", moore_flag, e);
            check("R3", "mealy_flag after sample", mealy_flag, 1'b0);
        end
        check("R5", "smealy_flag", smealy_flag, e);
        check("R6", "moore==smealy", moore_flag, smealy_flag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", "moore_flag in reset", moore_flag, 1'b0);
        check("R7", "mealy_flag in reset", mealy_flag, 1'b0);
        check("R7", "smealy_flag in reset", smealy_flag, 1'b0);

        // table walk: stream 001011010 (R1, R2 on the first bit)
        for (int i = 0; i < NBITS; i++)
            step(STREAM[NBITS-1-i], 1'b0, (i == 0) ? "R2" : "R1", 1'b1, EXPECT[NBITS-1-i]);

        // R9: long runs of ones then zeros
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R9", 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R9", 1'b0, 1'b0);

        // R8: reset with a bit that would flag
        step(1'b1, 1'b1, "R8", 1'b0, 1'b0);
        step(1'b1, 1'b1, "R8", 1'b0, 1'b0);
        // R4/R2: first bit after release differs from pre-reset history
        step(1'b0, 1'b0, "R2", 1'b0, 1'b0);
        step(1'b1, 1'b0, "R1", 1'b0, 1'b0);
        step(1'b0, 1'b0, "R1", 1'b0, 1'b0);
        step(1'b0, 1'b0, "R9", 1'b0, 1'b0);

        // R1: alternating pattern flags on every bit
        for (int i = 0; i < 8; i++) step(i[0], 1'b0, "R1", 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule